// File: doc/BRIEF.md
# Memory Read Request Issuer

This block sits on the client side of a memory controller's read port. An upstream queue offers read commands, each an address and a burst length, through a valid/ready handshake. The block places each accepted command in a one-entry holding register and drives it to the controller. While the controller reports busy, it keeps the command unchanged. It also keeps any two controller acceptances at least a configured number of cycles apart, even when upstream commands arrive back to back.

The controller returns read data a fixed number of cycles after it accepts a request. Beats are marked by a data-valid strobe and carry no tag. The block records each accepted request in a small in-order table that holds its burst length and the cycle on which it was accepted. Returned beats pass straight through to the client. The block counts beats against the oldest outstanding request and marks the final beat of each burst. Two sticky flags report return timing that breaks the fixed round trip and data that arrives when nothing is outstanding.

Top module: `rd_issuer`

## Requirements
- R1: An upstream command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. From the next cycle on it is shown as `mc_addr`/`mc_blen`. `mc_rd_req` goes high once spacing and table room allow. The controller accepts the request on a cycle where `mc_rd_req` is high and `mc_busy` is low, and `cmd_ready` is high exactly when the holding register is empty or is being accepted that cycle.
- R2: While `mc_rd_req` and `mc_busy` are both high, `cmd_ready` is low. On the following cycle `mc_rd_req` stays high with `mc_addr` and `mc_blen` unchanged.
- R3: Two controller acceptances are at least GAP cycles apart (default 5). If a command is waiting, the table has room and busy is low, the next acceptance happens exactly GAP cycles after the previous one.
- R4: `out_valid` and `out_data` copy `mc_rdata_valid` and `mc_rdata` in the same cycle. `out_last` is high on the beat that completes the oldest outstanding request. A request completes on its Nth beat for burst length N, and a burst length of 0 counts as one beat. Requests complete in acceptance order.
- R5: `lat_err` becomes and stays set if the first beat of the oldest outstanding request does not arrive exactly LATENCY cycles after its acceptance, whether it arrives earlier or later.
- R6: `proto_err` becomes and stays set when `mc_rdata_valid` is high while no request is outstanding.
- R7: No more than DEPTH requests are outstanding. `mc_rd_req` stays low while the table is full, and a slot freed by a final beat becomes usable on the next cycle.
- R8: A synchronous active-high `rst` empties the holding register and the table and clears the spacing counter and both flags. After reset `cmd_ready` is high, `mc_rd_req` is low, and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Upstream command offered |
| cmd_addr | input | ADDR_W (34) | Upstream read address |
| cmd_blen | input | BLEN_W (8) | Upstream burst length in beats |
| cmd_ready | output | 1 | Block can take a command this cycle |
| mc_rd_req | output | 1 | Read request to the controller |
| mc_addr | output | ADDR_W (34) | Address of the held request |
| mc_blen | output | BLEN_W (8) | Burst length of the held request |
| mc_busy | input | 1 | Controller cannot accept this cycle |
| mc_rdata_valid | input | 1 | Returned beat present |
| mc_rdata | input | DATA_W (288) | Returned beat data |
| out_valid | output | 1 | Beat delivered to the client |
| out_data | output | DATA_W (288) | Beat data to the client |
| out_last | output | 1 | Final beat of the oldest request |
| lat_err | output | 1 | Sticky round-trip timing error |
| proto_err | output | 1 | Sticky beat-with-nothing-outstanding error |

## Verification
The bench sweeps burst lengths 0 through 5 while upstream valid is held high, while valid toggles, and while busy pulses. It predicts every cycle's request, ready, address and last-beat value from the requirements. A spacing counter that is off by one shows up as an acceptance one cycle early or late. A hold register that reloads under busy changes the presented address. With a deliberately shallow table and short latency, a design that ignores fullness issues a third request before the first burst retires. Returns shifted one cycle early and one cycle late must each raise the latency flag. A stray beat with the table empty must raise the protocol flag and leave the latency flag alone. Both flags must clear on reset.

// File: rtl/rd_issuer_pkg.sv
package rd_issuer_pkg;

   typedef enum logic [0:0] {
      RDI_TABLE_SINGLE = 1'b0,
      RDI_TABLE_RING   = 1'b1
   } rdi_table_kind_e;

   function automatic rdi_table_kind_e rdi_pick_table(input int depth);
      return (depth == 1) ? RDI_TABLE_SINGLE : RDI_TABLE_RING;
   endfunction

   function automatic int rdi_ts_width(input int latency);
      return $clog2(latency + 1) + 2;
   endfunction

endpackage

// File: rtl/rd_issuer_pacer.sv
module rd_issuer_pacer #(
   parameter int ADDR_W = 34,
   parameter int BLEN_W = 8,
   parameter int GAP    = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [BLEN_W-1:0] cmd_blen,
   output logic              cmd_ready,
   input  logic              room,
   input  logic              mc_busy,
   output logic              mc_rd_req,
   output logic [ADDR_W-1:0] mc_addr,
   output logic [BLEN_W-1:0] mc_blen,
   output logic              fire
);
   localparam int GW = $clog2(GAP + 1);

   logic          held_q;
   logic [GW-1:0] space_q;

   assign mc_rd_req = held_q && (space_q == '0) && room;
   assign fire      = mc_rd_req && !mc_busy;
   assign cmd_ready = !held_q || fire;

   always_ff @(posedge clk) begin
      if (rst) begin
         held_q  <= 1'b0;
         mc_addr <= '0;
         mc_blen <= '0;
      end else if (cmd_ready) begin
         held_q <= cmd_valid;
         if (cmd_valid) begin
            mc_addr <= cmd_addr;
            mc_blen <= cmd_blen;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         space_q <= '0;
      end else if (fire) begin
         space_q <= GW'(GAP - 1);
      end else if (space_q != '0) begin
         space_q <= space_q - 1'b1;
      end
   end

endmodule

// File: rtl/rd_issuer_table.sv
module rd_issuer_table
   import rd_issuer_pkg::*;
#(
   parameter int W     = 12,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam rdi_table_kind_e KIND = rdi_pick_table(DEPTH);

   generate
      if (KIND == RDI_TABLE_SINGLE) begin : g_single
         logic         v_q;
         logic [W-1:0] d_q;
         assign empty = !v_q;
         assign full  = v_q;
         assign dout  = d_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               v_q <= 1'b0;
               d_q <= '0;
            end else if (push && !v_q) begin
               v_q <= 1'b1;
               d_q <= din;
            end else if (pop) begin
               v_q <= 1'b0;
            end
         end
      end else begin : g_ring
         localparam int AW = $clog2(DEPTH);
         localparam int CW = $clog2(DEPTH + 1);
         logic [W-1:0]  mem [DEPTH];
         logic [AW-1:0] rp_q, wp_q;
         logic [CW-1:0] cnt_q;
         logic          do_push, do_pop;

         assign empty   = (cnt_q == '0);
         assign full    = (cnt_q == CW'(DEPTH));
         assign dout    = mem[rp_q];
         assign do_push = push && !full;
         assign do_pop  = pop && !empty;

         always_ff @(posedge clk) begin
            if (do_push) mem[wp_q] <= din;
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               rp_q  <= '0;
               wp_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
               if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
               case ({do_push, do_pop})
                  2'b10:   cnt_q <= cnt_q + 1'b1;
                  2'b01:   cnt_q <= cnt_q - 1'b1;
                  default: cnt_q <= cnt_q;
               endcase
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rd_issuer_tracker.sv
module rd_issuer_tracker #(
   parameter int BLEN_W  = 8,
   parameter int TS_W    = 5,
   parameter int LATENCY = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              beat,
   input  logic              empty,
   input  logic [BLEN_W-1:0] head_blen,
   input  logic [TS_W-1:0]   head_ts,
   output logic [TS_W-1:0]   now_ts,
   output logic              pop,
   output logic              lat_err,
   output logic              proto_err
);
   logic [BLEN_W-1:0] got_q;
   logic [TS_W-1:0]   age;
   logic              closing, first_pending, timing_bad;

   assign age           = now_ts - head_ts;
   assign closing       = (head_blen == '0) ||
                          (({1'b0, got_q} + 1'b1) == {1'b0, head_blen});
   assign pop           = beat && !empty && closing;
   assign first_pending = !empty && (got_q == '0);
   assign timing_bad    = first_pending &&
                          (beat ? (age != TS_W'(LATENCY)) : (age == TS_W'(LATENCY)));

   always_ff @(posedge clk) begin
      if (rst) begin
         now_ts    <= '0;
         got_q     <= '0;
         lat_err   <= 1'b0;
         proto_err <= 1'b0;
      end else begin
         now_ts <= now_ts + 1'b1;
         if (pop)                got_q <= '0;
         else if (beat && !empty) got_q <= got_q + 1'b1;
         if (timing_bad)         lat_err   <= 1'b1;
         if (beat && empty)      proto_err <= 1'b1;
      end
   end

endmodule

// File: rtl/rd_issuer.sv
module rd_issuer
   import rd_issuer_pkg::*;
#(
   parameter int ADDR_W  = 34,
   parameter int BLEN_W  = 8,
   parameter int DATA_W  = 288,
   parameter int GAP     = 5,
   parameter int LATENCY = 16,
   parameter int DEPTH   = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [BLEN_W-1:0] cmd_blen,
   output logic              cmd_ready,
   output logic              mc_rd_req,
   output logic [ADDR_W-1:0] mc_addr,
   output logic [BLEN_W-1:0] mc_blen,
   input  logic              mc_busy,
   input  logic              mc_rdata_valid,
   input  logic [DATA_W-1:0] mc_rdata,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last,
   output logic              lat_err,
   output logic              proto_err
);
   localparam int TS_W = rdi_ts_width(LATENCY);
   localparam int EW   = BLEN_W + TS_W;

   generate
      if (GAP < 1 || GAP > 200) begin : g_bad_gap
         $error("rd_issuer: GAP must lie in 1..200");
      end
      if (LATENCY < 2) begin : g_bad_lat
         $error("rd_issuer: LATENCY must be at least 2");
      end
      if (DEPTH < 1 || DEPTH > 64) begin : g_bad_depth
         $error("rd_issuer: DEPTH must lie in 1..64");
      end
   endgenerate

   logic              fire, t_empty, t_full, t_pop;
   logic [EW-1:0]     t_head;
   logic [TS_W-1:0]   now_ts;

   rd_issuer_pacer #(.ADDR_W(ADDR_W), .BLEN_W(BLEN_W), .GAP(GAP)) u_pacer (
      .clk(clk), .rst(rst),
      .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_blen(cmd_blen),
      .cmd_ready(cmd_ready), .room(!t_full), .mc_busy(mc_busy),
      .mc_rd_req(mc_rd_req), .mc_addr(mc_addr), .mc_blen(mc_blen),
      .fire(fire)
   );

   rd_issuer_table #(.W(EW), .DEPTH(DEPTH)) u_table (
      .clk(clk), .rst(rst),
      .push(fire), .din({mc_blen, now_ts}),
      .pop(t_pop), .dout(t_head),
      .empty(t_empty), .full(t_full)
   );

   rd_issuer_tracker #(.BLEN_W(BLEN_W), .TS_W(TS_W), .LATENCY(LATENCY)) u_track (
      .clk(clk), .rst(rst),
      .beat(mc_rdata_valid), .empty(t_empty),
      .head_blen(t_head[EW-1:TS_W]), .head_ts(t_head[TS_W-1:0]),
      .now_ts(now_ts), .pop(t_pop),
      .lat_err(lat_err), .proto_err(proto_err)
   );

   assign out_valid = mc_rdata_valid;
   assign out_data  = mc_rdata;
   assign out_last  = t_pop;

endmodule

// File: rtl/rd_issuer_chk.sv
module rd_issuer_chk #(
   parameter int ADDR_W = 34,
   parameter int BLEN_W = 8,
   parameter int GAP    = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              cmd_ready,
   input logic              mc_rd_req,
   input logic [ADDR_W-1:0] mc_addr,
   input logic [BLEN_W-1:0] mc_blen,
   input logic              mc_busy,
   input logic              out_valid,
   input logic              out_last,
   input logic              lat_err,
   input logic              proto_err
);
   logic [7:0] since_q;
   logic       seen_q;
   logic       took;

   assign took = mc_rd_req && !mc_busy;

   always_ff @(posedge clk) begin
      if (rst) begin
         since_q <= '0;
         seen_q  <= 1'b0;
      end else if (took) begin
         since_q <= 8'd1;
         seen_q  <= 1'b1;
      end else if (since_q != 8'hFF) begin
         since_q <= since_q + 1'b1;
      end
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (mc_rd_req && mc_busy) |=> (mc_rd_req && $stable(mc_addr) && $stable(mc_blen))); // R2
   AST_NO_TAKE_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
      (mc_rd_req && mc_busy) |-> !cmd_ready); // R2
   AST_MIN_SPACING: assert property (@(posedge clk) disable iff (rst)
      took |-> (!seen_q || (int'(since_q) >= GAP))); // R3
   AST_LAST_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
      out_last |-> out_valid); // R4
   AST_LAT_STICKY: assert property (@(posedge clk) disable iff (rst)
      lat_err |=> lat_err); // R5
   AST_PROTO_STICKY: assert property (@(posedge clk) disable iff (rst)
      proto_err |=> proto_err); // R6
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!mc_rd_req && cmd_ready && !lat_err && !proto_err)); // R8

endmodule

bind rd_issuer rd_issuer_chk #(.ADDR_W(ADDR_W), .BLEN_W(BLEN_W), .GAP(GAP)) u_chk (
   .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .mc_rd_req(mc_rd_req),
   .mc_addr(mc_addr), .mc_blen(mc_blen), .mc_busy(mc_busy),
   .out_valid(out_valid), .out_last(out_last),
   .lat_err(lat_err), .proto_err(proto_err)
);

// File: tb/rd_issuer_bench.sv
module rd_issuer_bench;
   localparam int AW  = 34;
   localparam int BW  = 8;
   localparam int DW  = 288;
   localparam int GAP = 5;
   localparam int LAT = 6;
   localparam int DEP = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   logic          cmd_valid = 1'b0, cmd_ready;
   logic [AW-1:0] cmd_addr = '0, mc_addr;
   logic [BW-1:0] cmd_blen = '0, mc_blen;
   logic          mc_rd_req, mc_busy = 1'b0;
   logic          mc_rdata_valid = 1'b0;
   logic [DW-1:0] mc_rdata = '0, out_data;
   logic          out_valid, out_last, lat_err, proto_err;

   rd_issuer #(.ADDR_W(AW), .BLEN_W(BW), .DATA_W(DW), .GAP(GAP),
               .LATENCY(LAT), .DEPTH(DEP)) u_rd_issuer (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
      .cmd_blen(cmd_blen), .cmd_ready(cmd_ready), .mc_rd_req(mc_rd_req),
      .mc_addr(mc_addr), .mc_blen(mc_blen), .mc_busy(mc_busy),
      .mc_rdata_valid(mc_rdata_valid), .mc_rdata(mc_rdata),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
      .lat_err(lat_err), .proto_err(proto_err)
   );

   int n_cmp = 0, n_bad = 0, cyc = 0;
   int busy_mode = 0, vmode = 0, lat_off = 0, cmd_i = 0, cmd_end = 0;
   bit spur = 0;
   bit pend_m = 0, prev_hold = 0;
   logic [AW-1:0] pa_m = '0, hold_a = '0;
   logic [BW-1:0] pb_m = '0, hold_b = '0;
   int since = 1000, outst = 0, bk = 0;
   int eb[$];
   int rs_start[$], rs_nb[$];
   logic [AW-1:0] rs_addr[$];

   function automatic logic [AW-1:0] addr_of(input int i);
      return {2'b01, 32'(i * 40503 + 17)};
   endfunction
   function automatic logic [BW-1:0] blen_of(input int i);
      return BW'(i % 6);
   endfunction
   function automatic int nbeats(input logic [BW-1:0] b);
      return (b == '0) ? 1 : int'(b);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic step();
      bit exp_req, exp_fire, exp_ready, exp_last, resp_v;
      int k;
      @(negedge clk);
      cmd_valid = (cmd_i < cmd_end) && (vmode == 0 || (cyc % 3) != 0);
      cmd_addr  = addr_of(cmd_i);
      cmd_blen  = blen_of(cmd_i);
      mc_busy   = (busy_mode != 0) && ((cyc % 7) < 3);
      resp_v    = 1'b0;
      k         = 0;
      mc_rdata_valid = 1'b0;
      mc_rdata  = '0;
      if (spur) begin
         mc_rdata_valid = 1'b1;
         mc_rdata = {DW{1'b1}};
      end else if (rs_start.size() > 0 && cyc >= rs_start[0]) begin
         resp_v = 1'b1;
         k = cyc - rs_start[0];
         mc_rdata_valid = 1'b1;
         mc_rdata = {{(DW-AW-BW){1'b0}}, rs_addr[0], BW'(k)};
      end
      #1;
      exp_req = pend_m && (since >= GAP) && (outst < DEP);
      chk(mc_rd_req === exp_req, (pend_m && outst >= DEP) ? "R7 request while full" : "R3 request timing",
          64'(mc_rd_req), 64'(exp_req));
      if (exp_req) begin
         chk(mc_addr === pa_m, "R1 address", 64'(mc_addr), 64'(pa_m));
         chk(mc_blen === pb_m, "R1 burst length", 64'(mc_blen), 64'(pb_m));
      end
      exp_fire  = exp_req && !mc_busy;
      exp_ready = !pend_m || exp_fire;
      chk(cmd_ready === exp_ready, "R1 cmd_ready", 64'(cmd_ready), 64'(exp_ready));
      if (prev_hold)
         chk(mc_rd_req && mc_addr === hold_a && mc_blen === hold_b, "R2 hold under busy",
             64'(mc_addr), 64'(hold_a));
      chk(out_valid === mc_rdata_valid, "R4 out_valid", 64'(out_valid), 64'(mc_rdata_valid));
      if (mc_rdata_valid)
         chk(out_data === mc_rdata, "R4 out_data", out_data[63:0], mc_rdata[63:0]);
      exp_last = mc_rdata_valid && (eb.size() > 0) && (bk == eb[0] - 1);
      chk(out_last === exp_last, "R4 out_last", 64'(out_last), 64'(exp_last));
      // model updates for the coming edge
      prev_hold = mc_rd_req && mc_busy;
      hold_a = mc_addr;
      hold_b = mc_blen;
      if (mc_rdata_valid && eb.size() > 0) begin
         if (bk == eb[0] - 1) begin
            void'(eb.pop_front());
            bk = 0;
            outst--;
         end else begin
            bk++;
         end
      end
      if (mc_rd_req && !mc_busy) begin
         rs_start.push_back(cyc + LAT + lat_off);
         rs_nb.push_back(nbeats(mc_blen));
         rs_addr.push_back(mc_addr);
      end
      if (exp_fire) begin
         eb.push_back(nbeats(pb_m));
         outst++;
         since = 1;
      end else begin
         since++;
      end
      if (exp_ready) begin
         pend_m = cmd_valid;
         if (cmd_valid) begin
            pa_m = cmd_addr;
            pb_m = cmd_blen;
         end
      end
      if (cmd_valid && cmd_ready) cmd_i++;
      if (resp_v && k == rs_nb[0] - 1) begin
         void'(rs_start.pop_front());
         void'(rs_nb.pop_front());
         void'(rs_addr.pop_front());
      end
      spur = 1'b0;
      cyc++;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      cmd_valid = 1'b0;
      mc_rdata_valid = 1'b0;
      mc_busy = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      chk(cmd_ready === 1'b1, "R8 cmd_ready after reset", 64'(cmd_ready), 64'd1);
      chk(mc_rd_req === 1'b0, "R8 mc_rd_req after reset", 64'(mc_rd_req), 64'd0);
      chk(lat_err === 1'b0, "R8 lat_err after reset", 64'(lat_err), 64'd0);
      chk(proto_err === 1'b0, "R8 proto_err after reset", 64'(proto_err), 64'd0);
      rst = 1'b0;
      pend_m = 0; prev_hold = 0; since = 1000; outst = 0; bk = 0;
      eb.delete(); rs_start.delete(); rs_nb.delete(); rs_addr.delete();
      cmd_end = cmd_i;
   endtask

   task automatic run_cmds(input int n);
      cmd_end = cmd_i + n;
      while (!(cmd_i >= cmd_end && !pend_m && rs_start.size() == 0)) step();
      repeat (8) step();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      do_reset();
      // continuous upstream, no busy: exact spacing, table limit, burst sweep
      busy_mode = 0; vmode = 0; lat_off = 0;
      run_cmds(30);
      chk(lat_err === 1'b0, "R5 no false latency flag", 64'(lat_err), 64'd0);
      chk(proto_err === 1'b0, "R6 no false protocol flag", 64'(proto_err), 64'd0);
      // gapped upstream with busy pulses
      busy_mode = 1; vmode = 1;
      run_cmds(30);
      chk(lat_err === 1'b0, "R5 no false latency flag under busy", 64'(lat_err), 64'd0);
      chk(proto_err === 1'b0, "R6 no false protocol flag under busy", 64'(proto_err), 64'd0);
      // late return
      busy_mode = 0; vmode = 0; lat_off = 1;
      run_cmds(1);
      chk(lat_err === 1'b1, "R5 late first beat", 64'(lat_err), 64'd1);
      chk(proto_err === 1'b0, "R6 untouched by late beat", 64'(proto_err), 64'd0);
      do_reset();
      // early return
      lat_off = -1;
      run_cmds(1);
      chk(lat_err === 1'b1, "R5 early first beat", 64'(lat_err), 64'd1);
      do_reset();
      // stray beat with nothing outstanding
      lat_off = 0;
      spur = 1'b1;
      step();
      step();
      chk(proto_err === 1'b1, "R6 stray beat", 64'(proto_err), 64'd1);
      chk(lat_err === 1'b0, "R5 untouched by stray beat", 64'(lat_err), 64'd0);
      do_reset();
      // normal traffic again after reset
      busy_mode = 1; vmode = 0;
      run_cmds(12);
      chk(lat_err === 1'b0 && proto_err === 1'b0, "R8 clean after reset",
          64'({lat_err, proto_err}), 64'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule